// File: doc/BRIEF.md
# Power-of-Two Weight Neuron Datapath

This block produces one hidden-node output per clock for a small randomised single-layer network. A feature vector in signed fixed point arrives with the index of the hidden node to evaluate. A constant 1.0 is appended as an extra term, so the node's bias becomes one more weighted input. Every weight is a sign together with a power-of-two magnitude. Each product is therefore an arithmetic right shift, and the block needs no multipliers.

All input terms are shifted by every permitted amount at once, in parallel. A per-term selector then picks the shift that the node's weight word asks for. A term with a negative weight leaves the selector as its bitwise complement. The compensated adder adds back one unit for each complemented term. That count is stored in the weight ROM beside the signs. The sum feeds a piecewise-linear sigmoid. The weight ROM is a parameter vector fixed at elaboration. A controller outside the block issues node indices in any order, one per cycle.

Top module: `pow2_neuron`

## Requirements
- R1: Each feature is a signed two's-complement word of 1+INT_W+FRAC_W bits (default 16 bits, 12 fraction bits) packed with feature k at `feat_i[k*DATA_W +: DATA_W]`. A bias term with the constant value 1.0 (4096 by default) is term index N_FEAT.
- R2: The weight of term t of node n is a 3-bit code at bits `[(n*(N_FEAT+1)+t)*3 +: 3]` of `W_CODES`. Bit 2 is the sign (1 = negative) and bits 1:0 give the right-shift amount, 1 to 3. Shift code 0 means a zero weight: the term adds nothing, and it is neither inverted nor compensated, whatever its sign bit.
- R3: `pre_o` is exactly the sum over all terms of ±(term arithmetically shifted right), with floor rounding from the sign-extending shift, in FRAC_W fraction bits. A negative weight yields the exact two's-complement negation of the shifted term.
- R4: A request accepted with `valid_i` high produces `valid_o` high exactly two clock edges later, and `node_o` then equals that request's `node_i`.
- R5: Requests on consecutive cycles are all accepted, and the results come out in order, one per cycle.
- R6: `act_o` is unsigned with 15 fraction bits. It is 0 when pre ≤ −4.0 and 32768 when pre ≥ +4.0. Between those points it is 0.5 + pre/8, which for FRAC_W=12 equals 16384 + `pre_o`.
- R7: While no request is in flight, `pre_o`, `act_o` and `node_o` hold their values, whatever `feat_i` and `node_i` do, and `valid_o` is low.
- R8: Asynchronous reset clears `valid_o`, `node_o`, `pre_o` and `act_o` to 0 and drops any request in flight.
- R9: The adder is ceil(log2(N_FEAT+1)) bits wider than a feature. Full-scale features of either sign, with every weight at magnitude 1/2, produce the exact sum with no wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| node_i | input | $clog2(N_NODE) | Hidden node to evaluate |
| feat_i | input | N_FEAT*DATA_W | Packed feature vector |
| valid_o | output | 1 | Result strobe |
| node_o | output | $clog2(N_NODE) | Node index of the result |
| pre_o | output | DATA_W+$clog2(N_FEAT+1) | Signed pre-activation sum |
| act_o | output | 16 | Sigmoid output, 15 fraction bits |

## Verification
A wrong shift selection or a missing complement alters `pre_o` on the very result that uses the affected weight, two edges after the request. A wrong ones count in the ROM shows as an off-by-count error on every node that has negative weights. The inputs −1 and odd negative values expose floor rounding and the complement arithmetic in one result. A broken enable or reset in the register stages shows at once as `valid_o` out of step with the requests, or as outputs that move while idle.

// File: rtl/pow2_neuron_pkg.sv
`timescale 1ns/1ps
package pow2_neuron_pkg;
  localparam int unsigned SHIFT_W        = 2;
  localparam int unsigned CODE_W         = SHIFT_W + 1;
  localparam int unsigned ACT_W          = 16;
  localparam int unsigned ACT_FRAC       = ACT_W - 1;
  localparam int unsigned SIG_KNEE_LOG2  = 2;  // saturate beyond +-4.0
  localparam int unsigned SIG_SLOPE_LOG2 = 3;  // slope 1/8

  typedef struct packed {
    logic               neg;
    logic [SHIFT_W-1:0] sh;
  } wcode_t;
endpackage

// File: rtl/pow2_term_sel.sv
`timescale 1ns/1ps
module pow2_term_sel
  import pow2_neuron_pkg::*;
#(
  parameter int unsigned TERMS  = 5,
  parameter int unsigned DATA_W = 16
) (
  input  logic [TERMS*DATA_W-1:0] x_i,
  input  logic [TERMS*CODE_W-1:0] code_i,
  output logic [TERMS*DATA_W-1:0] term_o
);
  localparam int unsigned N_SH = 1 << SHIFT_W;

  for (genvar t = 0; t < TERMS; t++) begin : g_term
    logic signed [DATA_W-1:0] x;
    logic        [DATA_W-1:0] sh [N_SH];
    wcode_t                   c;
    logic                     inv;

    assign x = $signed(x_i[t*DATA_W +: DATA_W]);
    assign c = wcode_t'(code_i[t*CODE_W +: CODE_W]);

    // code 0 is a zero weight
    assign sh[0] = '0;
    for (genvar k = 1; k < N_SH; k++) begin : g_sh
      assign sh[k] = DATA_W'(x >>> k);
    end

    assign inv = c.neg && (c.sh != '0);
    assign term_o[t*DATA_W +: DATA_W] = inv ? ~sh[c.sh] : sh[c.sh];
  end
endmodule

// File: rtl/pow2_comp_sum.sv
`timescale 1ns/1ps
module pow2_comp_sum #(
  parameter int unsigned TERMS  = 5,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 3,
  parameter int unsigned SUM_W  = 19
) (
  input  logic        [TERMS*DATA_W-1:0] terms_i,
  input  logic        [CNT_W-1:0]        cnt_i,
  output logic signed [SUM_W-1:0]        sum_o
);
  logic signed [SUM_W-1:0] acc;

  always_comb begin
    // seed with the +1 owed by each complemented term
    acc = SUM_W'(cnt_i);
    for (int t = 0; t < TERMS; t++) begin
      acc = acc + SUM_W'($signed(terms_i[t*DATA_W +: DATA_W]));
    end
  end

  assign sum_o = acc;
endmodule

// File: rtl/pow2_sigmoid.sv
`timescale 1ns/1ps
module pow2_sigmoid
  import pow2_neuron_pkg::*;
#(
  parameter int unsigned SUM_W  = 19,
  parameter int unsigned FRAC_W = 12
) (
  input  logic signed [SUM_W-1:0] pre_i,
  output logic        [ACT_W-1:0] act_o
);
  localparam int SH    = int'(ACT_FRAC) - int'(FRAC_W) - int'(SIG_SLOPE_LOG2);
  localparam int EXT_W = SUM_W + ACT_W + 2;
  localparam logic signed [EXT_W-1:0] KNEE = EXT_W'(1) <<< (FRAC_W + SIG_KNEE_LOG2);
  localparam logic signed [EXT_W-1:0] HALF = EXT_W'(1) <<< (ACT_FRAC - 1);
  localparam logic        [ACT_W-1:0] ONE  = ACT_W'(1) << ACT_FRAC;

  logic signed [EXT_W-1:0] pre_x, scaled;

  assign pre_x = EXT_W'(pre_i);

  if (SH >= 0) begin : g_up
    assign scaled = pre_x <<< SH;
  end else begin : g_dn
    assign scaled = pre_x >>> (-SH);
  end

  always_comb begin
    if (pre_x >= KNEE)       act_o = ONE;
    else if (pre_x <= -KNEE) act_o = '0;
    else                     act_o = ACT_W'(HALF + scaled);
  end
endmodule

// File: rtl/pow2_neuron.sv
`timescale 1ns/1ps
module pow2_neuron
  import pow2_neuron_pkg::*;
#(
  parameter int unsigned N_FEAT = 4,
  parameter int unsigned INT_W  = 3,
  parameter int unsigned FRAC_W = 12,
  parameter int unsigned N_NODE = 8,
  parameter logic [N_NODE*(N_FEAT+1)*CODE_W-1:0] W_CODES =
    {(N_NODE*(N_FEAT+1)){3'b001}}
) (
  input  logic                                          clk_i,
  input  logic                                          rst_ni,
  input  logic                                          valid_i,
  input  logic [$clog2(N_NODE)-1:0]                     node_i,
  input  logic [N_FEAT*(1+INT_W+FRAC_W)-1:0]            feat_i,
  output logic                                          valid_o,
  output logic [$clog2(N_NODE)-1:0]                     node_o,
  output logic signed [(1+INT_W+FRAC_W)+$clog2(N_FEAT+1)-1:0] pre_o,
  output logic [ACT_W-1:0]                              act_o
);
  localparam int unsigned DATA_W = 1 + INT_W + FRAC_W;
  localparam int unsigned TERMS  = N_FEAT + 1;
  localparam int unsigned SUM_W  = DATA_W + $clog2(TERMS);
  localparam int unsigned CNT_W  = $clog2(TERMS + 1);
  localparam int unsigned NODE_W = $clog2(N_NODE);
  localparam int unsigned WORD_W = TERMS * CODE_W;
  localparam logic [DATA_W-1:0] BIAS_ONE = DATA_W'(1) << FRAC_W;

  function automatic int count_neg(input logic [WORD_W-1:0] w);
    int c;
    c = 0;
    for (int t = 0; t < TERMS; t++) begin
      if (w[t*CODE_W + SHIFT_W] && (w[t*CODE_W +: SHIFT_W] != '0)) c++;
    end
    return c;
  endfunction

  // weight ROM: codes plus precomputed complement count per node
  logic [WORD_W-1:0] rom_code [N_NODE];
  logic [CNT_W-1:0]  rom_cnt  [N_NODE];

  for (genvar n = 0; n < N_NODE; n++) begin : g_rom
    localparam logic [WORD_W-1:0] WORD = W_CODES[n*WORD_W +: WORD_W];
    assign rom_code[n] = WORD;
    assign rom_cnt[n]  = CNT_W'(count_neg(WORD));
  end

  logic [TERMS*DATA_W-1:0] x_ext;
  logic [TERMS*DATA_W-1:0] sel_terms;
  logic [WORD_W-1:0]       sel_code;
  logic [CNT_W-1:0]        sel_cnt;

  assign x_ext    = {BIAS_ONE, feat_i};
  assign sel_code = rom_code[node_i];
  assign sel_cnt  = rom_cnt[node_i];

  pow2_term_sel #(
    .TERMS  (TERMS),
    .DATA_W (DATA_W)
  ) u_sel (
    .x_i    (x_ext),
    .code_i (sel_code),
    .term_o (sel_terms)
  );

  // stage 1: selected and inverted terms
  logic                    vld_q;
  logic [NODE_W-1:0]       node_q;
  logic [TERMS*DATA_W-1:0] term_q;
  logic [CNT_W-1:0]        cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      node_q <= '0;
      term_q <= '0;
      cnt_q  <= '0;
    end else begin
      vld_q <= valid_i;
      if (valid_i) begin
        node_q <= node_i;
        term_q <= sel_terms;
        cnt_q  <= sel_cnt;
      end
    end
  end

  logic signed [SUM_W-1:0] sum_w;
  logic        [ACT_W-1:0] act_w;

  pow2_comp_sum #(
    .TERMS  (TERMS),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .SUM_W  (SUM_W)
  ) u_sum (
    .terms_i (term_q),
    .cnt_i   (cnt_q),
    .sum_o   (sum_w)
  );

  pow2_sigmoid #(
    .SUM_W  (SUM_W),
    .FRAC_W (FRAC_W)
  ) u_sig (
    .pre_i (sum_w),
    .act_o (act_w)
  );

  // stage 2: sum and activation
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      node_o  <= '0;
      pre_o   <= '0;
      act_o   <= '0;
    end else begin
      valid_o <= vld_q;
      if (vld_q) begin
        node_o <= node_q;
        pre_o  <= sum_w;
        act_o  <= act_w;
      end
    end
  end

  localparam logic        [ACT_W-1:0] ACT_ONE  = ACT_W'(1) << ACT_FRAC;
  localparam logic signed [SUM_W-1:0] PRE_KNEE = SUM_W'(1) <<< (FRAC_W + SIG_KNEE_LOG2);

  a_r4_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##2 valid_o);
  a_r4_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> ##2 !valid_o);
  a_r4_node_echo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##2 (node_o == $past(node_i, 2)));
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_q |=> ($stable(pre_o) && $stable(act_o) && $stable(node_o)));
  a_r6_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_o <= ACT_ONE);
  a_r6_sat_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (pre_o >= PRE_KNEE)) |-> (act_o == ACT_ONE));
  a_r6_sat_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (pre_o <= -PRE_KNEE)) |-> (act_o == '0));
endmodule

// File: tb/pow2_neuron_test.sv
`timescale 1ns/1ps
module pow2_neuron_test;
  localparam int NF = 4, IW = 3, FW = 12, NN = 8;
  localparam int TM = NF + 1, DW = 16, SW = 19, NW = 3, NV = 12;

  // weight codes {neg, shift[1:0]}, WT[node][term], term 4 = bias
  localparam logic [2:0] WT [NN][TM] = '{
    '{3'b001, 3'b001, 3'b001, 3'b001, 3'b001},
    '{3'b101, 3'b101, 3'b101, 3'b101, 3'b101},
    '{3'b001, 3'b110, 3'b011, 3'b111, 3'b010},
    '{3'b000, 3'b100, 3'b001, 3'b000, 3'b000},
    '{3'b011, 3'b011, 3'b111, 3'b111, 3'b101},
    '{3'b010, 3'b101, 3'b000, 3'b110, 3'b001},
    '{3'b101, 3'b001, 3'b110, 3'b010, 3'b111},
    '{3'b001, 3'b001, 3'b001, 3'b001, 3'b000}
  };

  function automatic logic [NN*TM*3-1:0] pack_w();
    logic [NN*TM*3-1:0] r;
    r = '0;
    for (int n = 0; n < NN; n++)
      for (int t = 0; t < TM; t++) r[(n*TM+t)*3 +: 3] = WT[n][t];
    return r;
  endfunction
  localparam logic [NN*TM*3-1:0] BW = pack_w();

  localparam int VN [NV] = '{0, 1, 2, 3, 4, 5, 6, 7, 0, 1, 0, 2};
  localparam int VF [NV][NF] = '{
    '{4096, 8192, -4096, 2048},
    '{4096, 8192, -4096, 2048},
    '{-1, 1, 12345, -12345},
    '{32767, -32768, 1000, 7},
    '{-300, 600, -900, 1200},
    '{20000, -20000, 3, -3},
    '{-1, -1, -1, -1},
    '{1, 2, 3, 5},
    '{32767, 32767, 32767, 32767},
    '{32767, 32767, 32767, 32767},
    '{-32768, -32768, -32768, -32768},
    '{0, 0, 0, 0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0;
  logic [NW-1:0] node = '0;
  logic [NF*DW-1:0] feat = '0;
  logic valid_o;
  logic [NW-1:0] node_o;
  logic signed [SW-1:0] pre_o;
  logic [15:0] act_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pow2_neuron #(
    .N_FEAT (NF), .INT_W (IW), .FRAC_W (FW), .N_NODE (NN), .W_CODES (BW)
  ) uut (
    .clk_i (clk), .rst_ni (rst_n), .valid_i (valid), .node_i (node),
    .feat_i (feat), .valid_o (valid_o), .node_o (node_o),
    .pre_o (pre_o), .act_o (act_o)
  );

  function automatic logic [NF*DW-1:0] pack_f(int i);
    logic [NF*DW-1:0] r;
    for (int k = 0; k < NF; k++) r[k*DW +: DW] = 16'(VF[i][k]);
    return r;
  endfunction

  // behavioural model with true shifts and negation
  function automatic int ref_pre(int nd, logic [NF*DW-1:0] fv);
    int sum, v, c, s;
    sum = 0;
    for (int t = 0; t < TM; t++) begin
      v = (t < NF) ? int'($signed(fv[t*DW +: DW])) : 4096;
      s = int'(WT[nd][t][1:0]);
      c = (s == 0) ? 0 : (v >>> s);
      if (WT[nd][t][2]) c = -c;
      sum += c;
    end
    return sum;
  endfunction

  function automatic int ref_act(int p);
    if (p >= 16384) return 32768;
    if (p <= -16384) return 0;
    return 16384 + p;
  endfunction

  function automatic string tag_of(int i);
    case (i)
      2, 6:    return "R3";
      3:       return "R2";
      8, 9:    return "R6";
      10:      return "R9";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int p, last_pre, last_act, last_node;
    // R8: reset state
    repeat (3) @(negedge clk);
    chk("R8", "valid_o", int'(valid_o), 0);
    chk("R8", "pre_o", int'(pre_o), 0);
    chk("R8", "act_o", int'(act_o), 0);
    chk("R8", "node_o", int'(node_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: back-to-back stream of the vector table
    for (int i = 0; i < NV + 2; i++) begin
      if (i >= 2) begin
        p = ref_pre(VN[i-2], pack_f(i-2));
        chk("R5", "valid_o", int'(valid_o), 1);
        chk(tag_of(i-2), "pre_o", int'(pre_o), p);
        chk("R6", "act_o", int'(act_o), ref_act(p));
        chk("R4", "node_o", int'(node_o), VN[i-2]);
      end
      if (i < NV) begin
        valid = 1'b1;
        node  = NW'(VN[i]);
        feat  = pack_f(i);
      end else begin
        valid = 1'b0;
      end
      @(negedge clk);
    end
    @(negedge clk);

    // R4: single request latency
    valid = 1'b1; node = 3'd5; feat = pack_f(5);
    @(negedge clk);
    valid = 1'b0;
    chk("R4", "valid_o after one edge", int'(valid_o), 0);
    @(negedge clk);
    p = ref_pre(5, pack_f(5));
    chk("R4", "valid_o after two edges", int'(valid_o), 1);
    chk("R4", "pre_o", int'(pre_o), p);
    chk("R4", "node_o", int'(node_o), 5);
    @(negedge clk);
    chk("R4", "valid_o pulse width", int'(valid_o), 0);

    // R7: idle inputs toggle, outputs hold
    last_pre = int'(pre_o); last_act = int'(act_o); last_node = int'(node_o);
    for (int k = 0; k < 4; k++) begin
      node = NW'(k + 1);
      feat = pack_f(k + 2);
      @(negedge clk);
      chk("R7", "valid_o", int'(valid_o), 0);
      chk("R7", "pre_o", int'(pre_o), last_pre);
      chk("R7", "act_o", int'(act_o), last_act);
      chk("R7", "node_o", int'(node_o), last_node);
    end

    // R8: reset with a request in flight
    valid = 1'b1; node = 3'd0; feat = pack_f(8);
    @(negedge clk);
    valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R8", "valid_o in reset", int'(valid_o), 0);
    chk("R8", "pre_o in reset", int'(pre_o), 0);
    chk("R8", "act_o in reset", int'(act_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8", "dropped request", int'(valid_o), 0);
    @(negedge clk);
    chk("R8", "dropped request later", int'(valid_o), 0);
    chk("R8", "pre_o after reset", int'(pre_o), 0);

    summary();
  end
endmodule